// File: doc/BRIEF.md
# Memory Mode Register with Command Legality Checker

This block stores the operating mode of a mobile DDR memory: the burst length, the burst ordering and the read latency. The controller or memory model that contains it sends every command through it. A mode-set command addressed to this register takes its new value from the low address bits. It is accepted only if all banks are idle, it is not issued during a wait period, and it carries no reserved or conflicting code.

The block also watches the rest of the command stream. It enforces a recovery wait of `WAIT_CYC` clock cycles after each accepted load, and a `busy` output shows that wait. It flags reads or writes that break the rules for full-page bursts. Each kind of violation has its own sticky flag, and only reset clears the flags. The stored mode is presented both as raw codes and in decoded form: a beat count, a full-page indication and the latency in cycles.

Top module: `mrs_guard`

## Requirements
- R1: After reset the stored mode holds length code 001 (2 beats), sequential order and latency code 010 (latency 2). `busy` is low and all six error flags are low.
- R2: Command codes are NOP=0, MODE_SET=1, ACTIVATE=2, READ=3, WRITE=4, PRECHARGE=5 and REFRESH=6. An accepted MODE_SET with `cmd_ba`=00 takes the length code from address bits [2:0], the order bit from bit 3 (1 = interleaved) and the latency code from bits [6:4]. The new value appears on the outputs from the next clock edge onward. Address bits above bit 6 are ignored.
- R3: The decoded outputs follow the stored codes. Length codes 001, 010, 011 and 100 give 2, 4, 8 and 16 beats. Length code 111 gives `full_page`=1 with `burst_beats`=0. Latency codes 010 and 011 give `cas_latency` 2 and 3.
- R4: A load with a reserved length code (000, 101, 110) or a reserved latency code (any code other than 010 or 011) sets `err_reserved` and leaves the register unchanged.
- R5: A load issued while any `bank_idle` bit is 0 sets `err_bank_active` and leaves the register unchanged. It sets no other flag.
- R6: After an accepted load, `busy` is high for exactly the next `WAIT_CYC` cycles. Any non-NOP command sampled while `busy` is high sets `err_timing` and is otherwise discarded.
- R7: A load that requests length code 111 with the interleaved bit set sets `err_fp_interleave` and leaves the register unchanged.
- R8: A READ or WRITE with `cmd_autopre`=1 while the stored length is full page sets `err_fp_autopre`.
- R9: A READ or WRITE whose column bit `cmd_addr[0]` is 1 while the stored length is full page sets `err_odd_col`. An even column, or any column when the length is not full page, sets no flag.
- R10: A MODE_SET with `cmd_ba` other than 00 does not change this register and sets no flag. Error flags stay set until reset. Commands other than an accepted load leave the stored mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_ba | input | 2 | Bank-address bits |
| cmd_addr | input | ADDR_W | Row/column address bits, carrying the mode fields on a load |
| cmd_autopre | input | 1 | Auto-precharge request on READ/WRITE |
| bank_idle | input | NUM_BANKS | One bit per bank, 1 when the bank is idle |
| mode_bl_code | output | 3 | Stored burst-length code |
| mode_interleave | output | 1 | Stored burst order, 1 = interleaved |
| mode_cl_code | output | 3 | Stored latency code |
| burst_beats | output | 5 | Decoded beats per burst, 0 for full page |
| full_page | output | 1 | Stored length is full page |
| cas_latency | output | 2 | Decoded read latency in cycles |
| busy | output | 1 | Post-load wait in progress |
| err_reserved | output | 1 | Sticky: load with a reserved code |
| err_bank_active | output | 1 | Sticky: load while a bank was active |
| err_timing | output | 1 | Sticky: command issued during the wait |
| err_fp_interleave | output | 1 | Sticky: full page requested with interleaving |
| err_fp_autopre | output | 1 | Sticky: full-page access with auto-precharge |
| err_odd_col | output | 1 | Sticky: full-page access at an odd column |

## Verification
The bench applies all 128 combinations of length code, order bit and latency code to a freshly reset block, with the unused upper address bits set. This separates accepted loads from reserved-code rejections and from the full-page/interleave conflict. A sweep over all sixteen idle-bank patterns checks that only the all-idle pattern allows a load. The bench issues commands 0 to `WAIT_CYC` cycles after a load to find the exact edge where the wait ends. READ and WRITE are each tried with every combination of auto-precharge and column parity, both in full-page mode and in a fixed-length mode. This shows that the burst-rule flags depend on the stored length.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

   typedef enum logic [2:0] {
      OP_NOP       = 3'd0,
      OP_MODE_SET  = 3'd1,
      OP_ACTIVATE  = 3'd2,
      OP_READ      = 3'd3,
      OP_WRITE     = 3'd4,
      OP_PRECHARGE = 3'd5,
      OP_REFRESH   = 3'd6
   } cmd_op_e;

   typedef struct packed {
      logic [2:0] bl;
      logic       bt;
      logic [2:0] cl;
   } mode_t;

   localparam mode_t MODE_RESET = '{bl: 3'b001, bt: 1'b0, cl: 3'b010};

   localparam int unsigned ERR_RESERVED   = 0;
   localparam int unsigned ERR_BANK       = 1;
   localparam int unsigned ERR_TIMING     = 2;
   localparam int unsigned ERR_FP_IL      = 3;
   localparam int unsigned ERR_FP_AP      = 4;
   localparam int unsigned ERR_ODD_COL    = 5;
   localparam int unsigned ERR_COUNT      = 6;

endpackage

// File: rtl/mrs_field_decode.sv
module mrs_field_decode
   import mrs_pkg::*;
(
   input  mode_t      mode,
   output logic       bl_ok,
   output logic       cl_ok,
   output logic       fp,
   output logic       fp_il,
   output logic [4:0] beats,
   output logic [1:0] cas
);

   always_comb begin
      bl_ok = 1'b0;
      beats = 5'd0;
      fp    = 1'b0;
      case (mode.bl)
         3'b001: begin bl_ok = 1'b1; beats = 5'd2;  end
         3'b010: begin bl_ok = 1'b1; beats = 5'd4;  end
         3'b011: begin bl_ok = 1'b1; beats = 5'd8;  end
         3'b100: begin bl_ok = 1'b1; beats = 5'd16; end
         3'b111: begin bl_ok = 1'b1; fp = 1'b1;     end
         default: ;
      endcase
   end

   always_comb begin
      cl_ok = 1'b0;
      cas   = 2'd2;
      case (mode.cl)
         3'b010: begin cl_ok = 1'b1; cas = 2'd2; end
         3'b011: begin cl_ok = 1'b1; cas = 2'd3; end
         default: ;
      endcase
   end

   assign fp_il = fp & mode.bt;

endmodule

// File: rtl/mrs_wait_timer.sv
module mrs_wait_timer #(
   parameter int unsigned WAIT_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   generate
      if (WAIT_CYC == 0) begin : g_no_wait
         assign busy = 1'b0;
      end else begin : g_wait
         localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1);
         localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (start) begin
               cnt_q <= CNT_LOAD;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign busy = (cnt_q != '0);
      end
   endgenerate

endmodule

// File: rtl/mrs_sticky_flags.sv
module mrs_sticky_flags #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   output logic [N-1:0] flags
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else if (set[i]) begin
               flag_q <= 1'b1;
            end
         end
         assign flags[i] = flag_q;
      end
   endgenerate

endmodule

// File: rtl/mrs_guard.sv
module mrs_guard
   import mrs_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned WAIT_CYC  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [1:0]           cmd_ba,
   input  logic [ADDR_W-1:0]    cmd_addr,
   input  logic                 cmd_autopre,
   input  logic [NUM_BANKS-1:0] bank_idle,
   output logic [2:0]           mode_bl_code,
   output logic                 mode_interleave,
   output logic [2:0]           mode_cl_code,
   output logic [4:0]           burst_beats,
   output logic                 full_page,
   output logic [1:0]           cas_latency,
   output logic                 busy,
   output logic                 err_reserved,
   output logic                 err_bank_active,
   output logic                 err_timing,
   output logic                 err_fp_interleave,
   output logic                 err_fp_autopre,
   output logic                 err_odd_col
);

   localparam int unsigned MODE_W = $bits(mode_t);

   generate
      if (ADDR_W < MODE_W) begin : g_chk_addr
         $error("mrs_guard: ADDR_W must cover the mode fields");
      end
      if (NUM_BANKS < 1) begin : g_chk_banks
         $error("mrs_guard: NUM_BANKS must be at least 1");
      end
   endgenerate

   mode_t mode_q;
   mode_t mode_req;

   logic in_bl_ok, in_cl_ok, in_fp, in_fp_il;
   logic [4:0] in_beats;
   logic [1:0] in_cas;
   logic st_bl_ok, st_cl_ok, st_fp, st_fp_il;

   logic cmd_live, is_load, all_idle, load_clear, codes_ok, load_ok, is_xfer;
   logic [ERR_COUNT-1:0] err_set;
   logic [ERR_COUNT-1:0] err_q;

   assign mode_req = '{bl: cmd_addr[2:0], bt: cmd_addr[3], cl: cmd_addr[6:4]};

   mrs_field_decode u_dec_req (
      .mode  (mode_req),
      .bl_ok (in_bl_ok),
      .cl_ok (in_cl_ok),
      .fp    (in_fp),
      .fp_il (in_fp_il),
      .beats (in_beats),
      .cas   (in_cas)
   );

   mrs_field_decode u_dec_state (
      .mode  (mode_q),
      .bl_ok (st_bl_ok),
      .cl_ok (st_cl_ok),
      .fp    (st_fp),
      .fp_il (st_fp_il),
      .beats (burst_beats),
      .cas   (cas_latency)
   );

   assign cmd_live   = cmd_valid && (cmd_op != OP_NOP);
   assign is_load    = cmd_valid && (cmd_op == OP_MODE_SET) && (cmd_ba == 2'b00);
   assign all_idle   = &bank_idle;
   assign load_clear = is_load && !busy && all_idle;
   assign codes_ok   = in_bl_ok && in_cl_ok;
   assign load_ok    = load_clear && codes_ok && !in_fp_il;
   assign is_xfer    = cmd_valid && !busy && st_fp &&
                       ((cmd_op == OP_READ) || (cmd_op == OP_WRITE));

   always_comb begin
      err_set               = '0;
      err_set[ERR_TIMING]   = cmd_live && busy;
      err_set[ERR_BANK]     = is_load && !busy && !all_idle;
      err_set[ERR_RESERVED] = load_clear && !codes_ok;
      err_set[ERR_FP_IL]    = load_clear && codes_ok && in_fp_il;
      err_set[ERR_FP_AP]    = is_xfer && cmd_autopre;
      err_set[ERR_ODD_COL]  = is_xfer && cmd_addr[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
      end else if (load_ok) begin
         mode_q <= mode_req;
      end
   end

   mrs_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (load_ok),
      .busy  (busy)
   );

   mrs_sticky_flags #(.N(ERR_COUNT)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_set),
      .flags (err_q)
   );

   assign mode_bl_code      = mode_q.bl;
   assign mode_interleave   = mode_q.bt;
   assign mode_cl_code      = mode_q.cl;
   assign full_page         = st_fp;
   assign err_reserved      = err_q[ERR_RESERVED];
   assign err_bank_active   = err_q[ERR_BANK];
   assign err_timing        = err_q[ERR_TIMING];
   assign err_fp_interleave = err_q[ERR_FP_IL];
   assign err_fp_autopre    = err_q[ERR_FP_AP];
   assign err_odd_col       = err_q[ERR_ODD_COL];

endmodule

// File: rtl/mrs_guard_chk.sv
module mrs_guard_chk
   import mrs_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned WAIT_CYC  = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_valid,
   input logic [2:0]           cmd_op,
   input logic [1:0]           cmd_ba,
   input logic [ADDR_W-1:0]    cmd_addr,
   input logic                 cmd_autopre,
   input logic [NUM_BANKS-1:0] bank_idle,
   input logic [2:0]           mode_bl_code,
   input logic                 mode_interleave,
   input logic [2:0]           mode_cl_code,
   input logic                 full_page,
   input logic [1:0]           cas_latency,
   input logic                 busy,
   input logic                 err_reserved,
   input logic                 err_bank_active,
   input logic                 err_timing,
   input logic                 err_fp_autopre
);

   logic [6:0] mode_v;
   assign mode_v = {mode_cl_code, mode_interleave, mode_bl_code};

   AST_LOAD_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_MODE_SET && cmd_ba == 2'b00 && !busy && !(&bank_idle))
      |=> (err_bank_active && $stable(mode_v))); // R5

   AST_BUSY_VIOLATION: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op != OP_NOP && busy) |=> err_timing); // R6

   AST_FP_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && (cmd_op == OP_READ || cmd_op == OP_WRITE) &&
       full_page && cmd_autopre) |=> err_fp_autopre); // R8

   AST_CAS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_latency == 2'd2) || (cas_latency == 2'd3)); // R4

   AST_FP_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      full_page |-> !mode_interleave); // R7

   AST_STICKY_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      err_timing |=> err_timing); // R10

   AST_STICKY_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      err_reserved |=> err_reserved); // R10

   generate
      if (WAIT_CYC > 0) begin : g_busy_chk
         AST_UPDATE_STARTS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(mode_v) |-> busy); // R6
      end
   endgenerate

endmodule

bind mrs_guard mrs_guard_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W),
   .WAIT_CYC  (WAIT_CYC)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cmd_valid       (cmd_valid),
   .cmd_op          (cmd_op),
   .cmd_ba          (cmd_ba),
   .cmd_addr        (cmd_addr),
   .cmd_autopre     (cmd_autopre),
   .bank_idle       (bank_idle),
   .mode_bl_code    (mode_bl_code),
   .mode_interleave (mode_interleave),
   .mode_cl_code    (mode_cl_code),
   .full_page       (full_page),
   .cas_latency     (cas_latency),
   .busy            (busy),
   .err_reserved    (err_reserved),
   .err_bank_active (err_bank_active),
   .err_timing      (err_timing),
   .err_fp_autopre  (err_fp_autopre)
);

// File: tb/mrs_guard_tb.sv
`timescale 1ns/1ps
module mrs_guard_tb;

   localparam int unsigned NUM_BANKS = 4;
   localparam int unsigned ADDR_W    = 13;
   localparam int unsigned WAIT_CYC  = 2;

   localparam logic [2:0] C_NOP = 3'd0, C_MRS = 3'd1, C_ACT = 3'd2,
                          C_RD  = 3'd3, C_WR  = 3'd4, C_PRE = 3'd5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [1:0] cmd_ba = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic cmd_autopre = 1'b0;
   logic [NUM_BANKS-1:0] bank_idle = '1;
   logic [2:0] mode_bl_code, mode_cl_code;
   logic mode_interleave, full_page, busy;
   logic [4:0] burst_beats;
   logic [1:0] cas_latency;
   logic err_reserved, err_bank_active, err_timing;
   logic err_fp_interleave, err_fp_autopre, err_odd_col;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   mrs_guard #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .cmd_autopre(cmd_autopre),
      .bank_idle(bank_idle), .mode_bl_code(mode_bl_code),
      .mode_interleave(mode_interleave), .mode_cl_code(mode_cl_code),
      .burst_beats(burst_beats), .full_page(full_page), .cas_latency(cas_latency),
      .busy(busy), .err_reserved(err_reserved), .err_bank_active(err_bank_active),
      .err_timing(err_timing), .err_fp_interleave(err_fp_interleave),
      .err_fp_autopre(err_fp_autopre), .err_odd_col(err_odd_col)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int flags();
      return {err_odd_col, err_fp_autopre, err_fp_interleave,
              err_timing, err_bank_active, err_reserved};
   endfunction

   function automatic int mode_word();
      return {mode_cl_code, mode_interleave, mode_bl_code};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = C_NOP; cmd_ba = '0;
      cmd_addr = '0; cmd_autopre = 1'b0; bank_idle = '1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic issue(input logic [2:0] op, input logic [1:0] ba,
                        input logic [ADDR_W-1:0] a, input logic ap);
      cmd_valid = 1'b1; cmd_op = op; cmd_ba = ba; cmd_addr = a; cmd_autopre = ap;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = C_NOP; cmd_ba = '0; cmd_addr = '0; cmd_autopre = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   function automatic logic [ADDR_W-1:0] mval(input int bl, input int bt, input int cl);
      logic [ADDR_W-1:0] a;
      a = '1;
      a[2:0] = bl[2:0];
      a[3]   = bt[0];
      a[6:4] = cl[2:0];
      return a;
   endfunction

   task automatic set_mode(input int bl, input int bt, input int cl);
      do_reset();
      issue(C_MRS, 2'b00, mval(bl, bt, cl), 1'b0);
      idle(WAIT_CYC);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      do_reset();
      check("R1 mode", mode_word(), 7'b010_0_001);
      check("R1 beats", burst_beats, 2);
      check("R1 cas", cas_latency, 2);
      check("R1 busy", busy, 0);
      check("R1 flags", flags(), 0);

      // R2 R3 R4 R7: full sweep of load fields
      for (int bl = 0; bl < 8; bl++) begin
         for (int bt = 0; bt < 2; bt++) begin
            for (int cl = 0; cl < 8; cl++) begin
               bit bl_ok, cl_ok, conflict, legal;
               int exp_beats, exp_mode;
               bl_ok = (bl >= 1 && bl <= 4) || bl == 7;
               cl_ok = (cl == 2) || (cl == 3);
               conflict = bl_ok && cl_ok && bl == 7 && bt == 1;
               legal = bl_ok && cl_ok && !conflict;
               do_reset();
               issue(C_MRS, 2'b00, mval(bl, bt, cl), 1'b0);
               exp_mode = legal ? (cl * 16 + bt * 8 + bl) : 7'b010_0_001;
               check("R2 mode fields", mode_word(), exp_mode);
               check("R4 reserved flag", err_reserved, !(bl_ok && cl_ok));
               check("R7 fp interleave flag", err_fp_interleave, conflict);
               if (legal) begin
                  exp_beats = (bl == 7) ? 0 : (1 << bl);
                  check("R3 beats", burst_beats, exp_beats);
                  check("R3 full page", full_page, bl == 7);
                  check("R3 cas", cas_latency, cl);
                  check("R6 busy after load", busy, WAIT_CYC > 0);
               end else begin
                  check("R4 busy stays low", busy, 0);
               end
            end
         end
      end

      // R5: every idle pattern
      for (int p = 0; p < (1 << NUM_BANKS); p++) begin
         bit ok;
         ok = (p == (1 << NUM_BANKS) - 1);
         do_reset();
         bank_idle = p[NUM_BANKS-1:0];
         issue(C_MRS, 2'b00, mval(3, 0, 3), 1'b0);
         check("R5 bank flag", err_bank_active, !ok);
         check("R5 mode", mode_word(), ok ? 7'b011_0_011 : 7'b010_0_001);
         check("R5 other flags", flags() & ~2, 0);
         bank_idle = '1;
      end

      // R6: busy profile
      do_reset();
      issue(C_MRS, 2'b00, mval(2, 0, 3), 1'b0);
      for (int j = 0; j < WAIT_CYC; j++) begin
         check("R6 busy during wait", busy, 1);
         idle(1);
      end
      check("R6 busy ends", busy, 0);
      check("R6 no flag when idle", err_timing, 0);

      // R6: command gap sweep
      for (int k = 0; k <= WAIT_CYC; k++) begin
         do_reset();
         issue(C_MRS, 2'b00, mval(2, 0, 3), 1'b0);
         idle(k);
         issue(C_ACT, 2'b01, '0, 1'b0);
         check("R6 gap timing flag", err_timing, k < WAIT_CYC);
      end

      // R6: load during wait is discarded
      do_reset();
      issue(C_MRS, 2'b00, mval(2, 0, 3), 1'b0);
      issue(C_MRS, 2'b00, mval(4, 1, 2), 1'b0);
      check("R6 discarded load flag", err_timing, 1);
      check("R6 discarded load mode", mode_word(), 7'b011_0_010);

      // R8 R9: full page and fixed-length transfers
      for (int fp = 0; fp < 2; fp++) begin
         for (int o = 0; o < 2; o++) begin
            for (int ap = 0; ap < 2; ap++) begin
               for (int col = 0; col < 2; col++) begin
                  logic [ADDR_W-1:0] a;
                  a = ADDR_W'(12 + col);
                  set_mode(fp ? 7 : 3, 0, 2);
                  issue(o ? C_WR : C_RD, 2'b10, a, ap[0]);
                  check("R8 autopre flag", err_fp_autopre, fp && ap);
                  check("R9 odd column flag", err_odd_col, fp && col);
                  check("R8 R9 other flags", flags() & 7'b001111, 0);
               end
            end
         end
      end

      // R10: other bank-address loads ignored
      for (int b = 1; b < 4; b++) begin
         set_mode(2, 0, 3);
         issue(C_MRS, b[1:0], mval(4, 1, 2), 1'b0);
         check("R10 other bank mode", mode_word(), 7'b011_0_010);
         check("R10 other bank flags", flags(), 0);
         check("R10 other bank busy", busy, 0);
      end

      // R10: stickiness and mode held across commands
      set_mode(7, 0, 3);
      issue(C_RD, 2'b00, 13'd5, 1'b1);
      issue(C_ACT, 2'b00, '0, 1'b0);
      issue(C_PRE, 2'b00, '0, 1'b0);
      issue(C_NOP, 2'b00, '0, 1'b0);
      idle(3);
      check("R10 sticky autopre", err_fp_autopre, 1);
      check("R10 sticky odd col", err_odd_col, 1);
      check("R10 mode held", mode_word(), 7'b011_0_111);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule